// File: doc/BRIEF.md
# Two-Ring Bus Arbiter

The block grants a shared parallel bus to one of five requesters. Four are external masters with active-low request lines. The fifth is the local translation-unit master, which has an active-high request. Exactly one grant is active at any time. The grant can move to another requester only on a cycle where the bus-idle input is high.

A 16-bit control register places each requester in either the high ring or the low ring. Each ring rotates round-robin. The low ring as a whole fills one slot in the high ring's rotation. A ring with no requesting member is skipped, so no cycle is lost. One more register bit picks the parking target used when nobody is requesting: either the last owner or the local translation-unit master.

Software writes the register through a simple write-enable port and reads it back at any time. Reserved bits always read as zero.

Top module: `two_ring_arb`

## Requirements
- R1: After reset the register reads 0x0000, the translation-unit grant (tu_gnt_o) is high, and all external grants are high (inactive).
- R2: A write stores only bit 8 (park mode), bit 6 (translation-unit ring) and bits 3:0 (external ring, bit n for request line n). Every other bit reads as zero, so writing 0xFFFF reads back as 0x014F.
- R3: The grant is registered. It changes only at a clock edge where bus_idle_i is high, and it holds while bus_idle_i is low.
- R4: Exactly one grant is active at any time. gnt_no[n] low grants the master on req_ni[n]. tu_gnt_o high grants the translation unit.
- R5: When any requester is asserting at an idle edge, the new owner is one of the requesters asserting at that edge.
- R6: In the high ring, members are served round-robin, starting after the last high-ring winner. The low-ring slot sits last in that rotation, after member 4. With requesters 0 and 1 high and all five requesting, the grant order is 0,1,2,0,1,3,0,1,4.
- R7: In the low ring, members are served round-robin, starting after the last low-ring winner. With every requester low and all requesting, the order from reset is 0,1,2,3,4,0,...
- R8: With bit 8 clear and no requests, the grant stays on the last owner.
- R9: With bit 8 set and no requests, the grant goes to the translation unit.
- R10: A register write takes effect at the first arbitration decision after the write edge. The decision made at the write edge itself still uses the old setting.
- R11: Bit 6 set places the translation unit in the high ring. With only bit 6 set and all requesting, the order is 4,0,4,1,4,2,4,3,4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| req_ni | input | 4 | External master requests, active low |
| tu_req_i | input | 1 | Translation-unit request, active high |
| bus_idle_i | input | 1 | Bus idle; grant may change |
| gnt_no | output | 4 | External master grants, active low |
| tu_gnt_o | output | 1 | Translation-unit grant, active high |

## Verification
The grant lines are driven from a single owner register, and the register read port is driven from the stored fields. A request or idle change applied before edge k therefore appears on the grant lines just after edge k. A register write appears on reg_rdata_o just after its edge, but it first steers arbitration at edge k+1. The bench drives inputs on falling edges and samples one falling edge after the rising edge of interest, so each check sees exactly one arbitration step. A sweep over 32 request patterns and several ring/park settings, with idle gaps, compares every step against an arithmetic rotation model.

// File: rtl/two_ring_arb_pkg.sv
package two_ring_arb_pkg;
  localparam int unsigned CFG_W       = 16;
  localparam int unsigned TU_RING_BIT = 6;
  localparam int unsigned PARK_BIT    = 8;
  localparam int unsigned MAX_EXT     = 4;
endpackage

// File: rtl/arb_rr_pick.sv
// Round-robin search: first set request strictly after ptr_i, wrapping.
module arb_rr_pick #(
  parameter int unsigned N  = 5,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  int p;
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    p       = 0;
    // descending so the nearest candidate wins last
    for (int i = N; i >= 1; i--) begin
      p = (int'(ptr_i) + i) % N;
      if (req_i[p]) begin
        found_o = 1'b1;
        idx_o   = IW'(p);
      end
    end
  end
endmodule

// File: rtl/arb_ctl_reg.sv
module arb_ctl_reg
  import two_ring_arb_pkg::*;
#(
  parameter int unsigned NUM_EXT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [CFG_W-1:0]   wdata_i,
  output logic [CFG_W-1:0]   rdata_o,
  output logic [NUM_EXT-1:0] ext_hi_o,
  output logic               tu_hi_o,
  output logic               park_local_o
);
  localparam logic [CFG_W-1:0] RW_MASK =
    CFG_W'((1 << NUM_EXT) - 1) | CFG_W'(1 << TU_RING_BIT) | CFG_W'(1 << PARK_BIT);

  logic [NUM_EXT-1:0] ext_hi_q;
  logic               tu_hi_q, park_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_hi_q <= '0;
      tu_hi_q  <= 1'b0;
      park_q   <= 1'b0;
    end else if (we_i) begin
      ext_hi_q <= wdata_i[NUM_EXT-1:0];
      tu_hi_q  <= wdata_i[TU_RING_BIT];
      park_q   <= wdata_i[PARK_BIT];
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[NUM_EXT-1:0]   = ext_hi_q;
    rdata_o[TU_RING_BIT]   = tu_hi_q;
    rdata_o[PARK_BIT]      = park_q;
  end

  assign ext_hi_o     = ext_hi_q;
  assign tu_hi_o      = tu_hi_q;
  assign park_local_o = park_q;

  // R2
  reg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == ($past(wdata_i) & RW_MASK));
endmodule

// File: rtl/two_ring_arb.sv
module two_ring_arb
  import two_ring_arb_pkg::*;
#(
  parameter int unsigned NUM_EXT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [CFG_W-1:0]   reg_wdata_i,
  output logic [CFG_W-1:0]   reg_rdata_o,
  input  logic [NUM_EXT-1:0] req_ni,
  input  logic               tu_req_i,
  input  logic               bus_idle_i,
  output logic [NUM_EXT-1:0] gnt_no,
  output logic               tu_gnt_o
);
  localparam int unsigned N    = NUM_EXT + 1;   // requesters
  localparam int unsigned HN   = N + 1;         // high ring incl. low-ring slot
  localparam int unsigned OW   = $clog2(N);
  localparam int unsigned HW   = $clog2(HN);
  localparam int unsigned TU   = NUM_EXT;
  localparam int unsigned SLOT = N;

  logic [NUM_EXT-1:0] ext_hi;
  logic               tu_hi, park_local;

  arb_ctl_reg #(.NUM_EXT(NUM_EXT)) u_reg (
    .clk_i, .rst_ni,
    .we_i         (reg_we_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .ext_hi_o     (ext_hi),
    .tu_hi_o      (tu_hi),
    .park_local_o (park_local)
  );

  logic [N-1:0]  req_vec, hi_mask, hi_req, lo_req, gnt_vec;
  logic [HN-1:0] hi_cand;
  logic [OW-1:0] owner_q, owner_d, lo_ptr_q, lo_ptr_d, lo_idx;
  logic [HW-1:0] hi_ptr_q, hi_ptr_d, hi_idx;
  logic          hi_found, lo_found;

  assign req_vec = {tu_req_i, ~req_ni};
  assign hi_mask = {tu_hi, ext_hi};
  assign hi_req  = req_vec & hi_mask;
  assign lo_req  = req_vec & ~hi_mask;
  assign hi_cand = {|lo_req, hi_req};

  arb_rr_pick #(.N(HN)) u_hi (
    .req_i(hi_cand), .ptr_i(hi_ptr_q), .found_o(hi_found), .idx_o(hi_idx));
  arb_rr_pick #(.N(N)) u_lo (
    .req_i(lo_req), .ptr_i(lo_ptr_q), .found_o(lo_found), .idx_o(lo_idx));

  always_comb begin
    owner_d  = owner_q;
    hi_ptr_d = hi_ptr_q;
    lo_ptr_d = lo_ptr_q;
    if (hi_found) begin
      hi_ptr_d = hi_idx;
      if (hi_idx == HW'(SLOT) && lo_found) begin
        owner_d  = lo_idx;
        lo_ptr_d = lo_idx;
      end else begin
        owner_d = OW'(hi_idx);
      end
    end else if (park_local) begin
      owner_d = OW'(TU);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OW'(TU);
      hi_ptr_q <= HW'(SLOT);   // first high pick starts at member 0
      lo_ptr_q <= OW'(N - 1);  // first low pick starts at member 0
    end else if (bus_idle_i) begin
      owner_q  <= owner_d;
      hi_ptr_q <= hi_ptr_d;
      lo_ptr_q <= lo_ptr_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign gnt_vec[g] = (owner_q == OW'(g));
  end
  assign gnt_no   = ~gnt_vec[NUM_EXT-1:0];
  assign tu_gnt_o = gnt_vec[TU];

  // R3
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_idle_i |=> $stable({tu_gnt_o, gnt_no}));
  // R4
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tu_gnt_o, ~gnt_no}) == 1);
  // R5
  gnt_requester_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_i && |req_vec) |=> |({tu_gnt_o, ~gnt_no} & $past(req_vec)));
  // R9
  park_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_i && !(|req_vec) && park_local) |=> tu_gnt_o);
endmodule

// File: tb/sim_two_ring_arb.sv
module sim_two_ring_arb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, tu_req = 1'b0, idle = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  req_n = 4'hF, gnt_n;
  logic        tu_gnt;
  int checks = 0, errors = 0, cyc = 0;

  // model state
  int m_owner, m_hp, m_lp;
  logic [15:0] m_cfg;

  always #10 clk = ~clk;

  two_ring_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .req_ni(req_n), .tu_req_i(tu_req),
    .bus_idle_i(idle), .gnt_no(gnt_n), .tu_gnt_o(tu_gnt));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int owner_now();
    int o = -1, n = 0;
    if (tu_gnt) begin o = 4; n++; end
    for (int i = 0; i < 4; i++) if (!gnt_n[i]) begin o = i; n++; end
    return (n == 1) ? o : -1;
  endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 0; idle = 0; req_n = 4'hF; tu_req = 0;
    step(); rst_n = 1'b1; step();
    m_owner = 4; m_hp = 5; m_lp = 4; m_cfg = '0;
  endtask

  task automatic wr(logic [15:0] v);
    we = 1; wdata = v; step(); we = 0;
    m_cfg = v & 16'h014F;
  endtask

  // reference: position of next requester after ptr in a ring of size n
  function automatic int nxt(int mask, int ptr, int n);
    for (int k = 1; k <= n; k++)
      if ((mask >> ((ptr + k) % n)) & 1) return (ptr + k) % n;
    return -1;
  endfunction

  task automatic model(logic [4:0] r);
    int hm, hr, lr, h, l;
    hm = {m_cfg[6], m_cfg[3:0]};
    hr = r & hm;
    lr = r & ~hm & 5'h1F;
    h  = nxt(hr | ((lr != 0) ? 32 : 0), m_hp, 6);
    if (h < 0) begin
      if (m_cfg[8]) m_owner = 4;
    end else begin
      m_hp = h;
      if (h == 5) begin
        l = nxt(lr, m_lp, 5); m_lp = l; m_owner = l;
      end else m_owner = h;
    end
  endtask

  task automatic run_seq(string tag, logic [15:0] cfg, int exp[9]);
    do_reset();
    wr(cfg);
    req_n = 4'h0; tu_req = 1; idle = 1;
    for (int k = 0; k < 9; k++) begin
      step();
      chk(tag, owner_now(), exp[k]);
    end
    idle = 0;
  endtask

  initial begin
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 rdata", int'(rdata), 0);
    chk("R1 tu_gnt", int'(tu_gnt), 1);
    chk("R1 gnt_n", int'(gnt_n), 15);
    // R2
    wr(16'hFFFF); chk("R2 mask", int'(rdata), 16'h014F);
    wr(16'h0000); chk("R2 clear", int'(rdata), 0);
    // R3: no change while bus busy
    do_reset();
    req_n = 4'b1101;
    for (int k = 0; k < 3; k++) begin step(); chk("R3 hold", owner_now(), 4); end
    idle = 1; step(); chk("R3 move", owner_now(), 1);
    // R8: park on last
    req_n = 4'hF; step(); step(); chk("R8 park last", owner_now(), 1);
    // R9: park local
    idle = 0; wr(16'h0100); idle = 1;
    step(); chk("R9 park tu", owner_now(), 4);
    req_n = 4'b1011; step(); chk("R9 serve", owner_now(), 2);
    req_n = 4'hF; step(); chk("R9 return", owner_now(), 4);
    idle = 0;
    // R6, R7, R11 ordering
    run_seq("R6", 16'h0003, '{0, 1, 2, 0, 1, 3, 0, 1, 4});
    run_seq("R7", 16'h0000, '{0, 1, 2, 3, 4, 0, 1, 2, 3});
    run_seq("R11 tu", 16'h0040, '{4, 0, 4, 1, 4, 2, 4, 3, 4});
    run_seq("R11 mix", 16'h004A, '{1, 3, 4, 0, 1, 3, 4, 2, 1});
    // R6: low ring requester only, high ring set but idle -> no lost cycle
    do_reset(); wr(16'h0003);
    req_n = 4'b1011; idle = 1; step(); chk("R6 skip", owner_now(), 2);
    idle = 0;
    // R10: write at the same edge as a decision
    do_reset();
    req_n = 4'h0; tu_req = 1; idle = 1;
    we = 1; wdata = 16'h0008; step(); we = 0;
    chk("R10 old cfg", owner_now(), 0);
    step(); chk("R10 new cfg", owner_now(), 3);
    step(); chk("R10 low slot", owner_now(), 1);
    idle = 0;
    // R4/R5 sweep vs model
    begin
      logic [15:0] cfgs[8] = '{16'h0000, 16'h0003, 16'h0005, 16'h0040,
                               16'h004A, 16'h010F, 16'h014F, 16'h0100};
      foreach (cfgs[c]) begin
        do_reset(); wr(cfgs[c]);
        for (int k = 0; k < 96; k++) begin
          logic [4:0] r;
          r = 5'((k * 7 + c * 3) % 32);
          if (k % 11 == 10) r = 5'h00;
          req_n = ~r[3:0]; tu_req = r[4]; idle = (k % 3 != 2);
          if (idle) model(r);
          step();
          chk("R5 sweep", owner_now(), m_owner);
        end
        idle = 0;
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule